// File: doc/BRIEF.md
# Port Pin Edge Interrupt Controller

This block watches 32 asynchronous general-purpose port pins and turns their transitions into interrupt requests. Each pin goes through its own synchronizer and edge detector. A per-line control bit picks one of two detection modes: falling edges only, or any transition. Every detected edge sets a sticky bit in an event register. Software clears that bit by writing a one to it. A mask register decides which pending events reach the single summary request that goes to a parent controller.

Software reaches the three registers through a simple 32-bit port with a byte address, a write strobe and combinational read data. Line numbers run from the most significant bit downward, so line 0 is bit 31 of every register. The block also reports which pending, unmasked line should be serviced next: the highest-numbered one. This saves the handler from doing its own bit search.

Top module: `pin_edge_irq`

## Requirements
- R1: Line n is held in bit (31 - n) of every register. The event register sits at byte offset 0x0C, the mask register at 0x10 and the control register at 0x14. All three are read through `reg_rdata` while `reg_addr` selects them.
- R2: After reset, the event, mask and control registers all read zero, and `irq_o` and `next_valid_o` are low.
- R3: A line whose control bit is 0 records both rising and falling pin transitions. Its event bit reads one after the third rising clock edge that follows the pin change.
- R4: A line whose control bit is 1 records only falling transitions. A rising transition on that line leaves its event bit at zero.
- R5: A write to the event offset clears every event bit written with 1. Bits written with 0 keep their value.
- R6: An edge sets its event bit even while the line is masked. The mask and control registers read back exactly the value last written to them.
- R7: `irq_o` is high exactly when at least one bit is set in both the event and mask registers.
- R8: `next_valid_o` is high when some event bit is set together with its mask bit. `next_line_o` then gives the largest line number among those bits, which is 31 minus the lowest such bit position.
- R9: When a new edge and a write-one-to-clear hit the same event bit in the same clock cycle, the bit stays set.
- R10: A read from any offset other than 0x0C, 0x10 or 0x14 returns zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pin_i | input | 32 | Asynchronous port pins; pin_i[n] is line n |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 1 | Summary interrupt toward the parent controller |
| next_valid_o | output | 1 | A pending unmasked line exists |
| next_line_o | output | 5 | Number of the line to service next |

## Verification
A pin change travels through two synchronizer flops and then the event flop, so its event bit, `irq_o` and `next_line_o` change after the third rising edge following the change. The bench drives each pin on a falling edge, waits three rising edges, and samples on the next falling edge. Register writes take effect at the single rising edge inside the write strobe. Read data is combinational, so the bench samples it shortly after it sets the address, with no clock edge in between. The collision case in R9 places the clearing write on exactly the third rising edge after a pin change, so that edge and clear meet in the same cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned NUM_LINES = 32;
  localparam int unsigned LINE_W    = $clog2(NUM_LINES);
  localparam int unsigned OFS_EVENT = 'h0C;
  localparam int unsigned OFS_MASK  = 'h10;
  localparam int unsigned OFS_CTRL  = 'h14;

  typedef enum logic [1:0] {SEL_NONE, SEL_EVENT, SEL_MASK, SEL_CTRL} reg_sel_e;

  // register bit that holds a given line (line 0 is the MSB)
  function automatic int unsigned bit_of_line(int unsigned line, int unsigned n);
    return n - 1 - line;
  endfunction
endpackage

// File: rtl/pin_edge_cell.sv
module pin_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_only_i,
  output logic edge_o
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  logic rise_w, fall_w;
  assign rise_w = sync2_q & ~prev_q;
  assign fall_w = ~sync2_q & prev_q;
  assign edge_o = fall_only_i ? fall_w : (rise_w | fall_w);

  // R4
  fall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_only_i && edge_o) |-> (!sync2_q && $past(sync2_q)));
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned N      = NUM_LINES,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N-1:0]      wdata,
  input  logic [N-1:0]      edge_vec,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      event_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      ctrl_o
);
  reg_sel_e sel_w;
  always_comb begin
    if (addr == ADDR_W'(OFS_EVENT))     sel_w = SEL_EVENT;
    else if (addr == ADDR_W'(OFS_MASK)) sel_w = SEL_MASK;
    else if (addr == ADDR_W'(OFS_CTRL)) sel_w = SEL_CTRL;
    else                                sel_w = SEL_NONE;
  end

  // named internal events for the checks
  logic [N-1:0] clr_vec;
  logic         mask_wr, ctrl_wr, stray_wr;
  assign clr_vec  = (wr_en && sel_w == SEL_EVENT) ? wdata : '0;
  assign mask_wr  = wr_en && sel_w == SEL_MASK;
  assign ctrl_wr  = wr_en && sel_w == SEL_CTRL;
  assign stray_wr = wr_en && sel_w == SEL_NONE;

  logic [N-1:0] event_q, mask_q, ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= '0;
      mask_q  <= '0;
      ctrl_q  <= '0;
    end else begin
      event_q <= (event_q & ~clr_vec) | edge_vec;
      if (mask_wr) mask_q <= wdata;
      if (ctrl_wr) ctrl_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel_w)
      SEL_EVENT: rdata = event_q;
      SEL_MASK:  rdata = mask_q;
      SEL_CTRL:  rdata = ctrl_q;
      default:   rdata = '0;
    endcase
  end

  assign event_o = event_q;
  assign mask_o  = mask_q;
  assign ctrl_o  = ctrl_q;

  // R2
  always @(posedge clk) if (!rst_n) reset_zero_chk: assert (event_q == '0 && mask_q == '0 && ctrl_q == '0);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_vec & ~edge_vec) |=> (event_q & $past(clr_vec & ~edge_vec)) == '0);

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |edge_vec |=> (event_q & $past(edge_vec)) == $past(edge_vec));

  // R3
  event_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (event_q & ~$past(event_q) & ~$past(edge_vec)) == '0);

  // R6
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == $past(wdata));

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> (mask_q == $past(mask_q) && ctrl_q == $past(ctrl_q)));
endmodule

// File: rtl/pin_irq_pick.sv
module pin_irq_pick
  import pin_irq_pkg::*;
#(
  parameter int unsigned N  = NUM_LINES,
  parameter int unsigned LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  output logic          valid_o,
  output logic [LW-1:0] line_o
);
  // lowest set bit belongs to the highest-numbered line
  always_comb begin
    valid_o = 1'b0;
    line_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (!valid_o && pend_i[i]) begin
        valid_o = 1'b1;
        line_o  = LW'(N - 1 - i);
      end
    end
  end

  // R8
  pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pend_i[bit_of_line(32'(line_o), N)] && ((pend_i << (32'(line_o) + 1)) == '0)));

  // R8
  pick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> pend_i == '0);
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_irq_pkg::*;
#(
  parameter int unsigned N      = NUM_LINES,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned LW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pin_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  output logic              irq_o,
  output logic              next_valid_o,
  output logic [LW-1:0]     next_line_o
);
  logic [N-1:0] edge_vec, event_w, mask_w, ctrl_w, pend_w;

  for (genvar ln = 0; ln < N; ln++) begin : g_line
    localparam int unsigned B = bit_of_line(ln, N);
    pin_edge_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_i[ln]),
      .fall_only_i(ctrl_w[B]),
      .edge_o     (edge_vec[B])
    );
  end

  pin_irq_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr_en   (reg_we),
    .wdata   (reg_wdata),
    .edge_vec(edge_vec),
    .rdata   (reg_rdata),
    .event_o (event_w),
    .mask_o  (mask_w),
    .ctrl_o  (ctrl_w)
  );

  assign pend_w = event_w & mask_w;
  assign irq_o  = |pend_w;

  pin_irq_pick #(.N(N), .LW(LW)) u_pick (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_w),
    .valid_o(next_valid_o),
    .line_o (next_line_o)
  );

  // R7
  irq_pick_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == next_valid_o);
endmodule

// File: tb/pin_edge_irq_bench.sv
module pin_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, next_valid_o;
  logic [4:0]  next_line_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_edge_irq u_pin_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .next_valid_o(next_valid_o), .next_line_o(next_line_o)
  );

  localparam logic [7:0] A_EV = 8'h0C, A_MK = 8'h10, A_CT = 8'h14;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  // drive pins, then wait until the event flop has taken the edge
  task automatic drive(input logic [31:0] v);
    @(negedge clk); pin_i = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // bench-side model of the service choice: scan from line 31 downward
  function automatic int want_line(input logic [31:0] pend);
    for (int ln = 31; ln >= 0; ln--) if (pend[31 - ln]) return ln;
    return -1;
  endfunction

  task automatic chk_out(input string req, input logic [31:0] ev, input logic [31:0] mk);
    logic [31:0] p;
    int wl;
    p  = ev & mk;
    wl = want_line(p);
    chk({req, " irq"}, {31'b0, irq_o}, {31'b0, p != 0});
    chk({req, " valid"}, {31'b0, next_valid_o}, {31'b0, wl >= 0});
    if (wl >= 0) chk({req, " line"}, {27'b0, next_line_o}, 32'(wl));
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R2 reset state
    rd(A_EV, d); chk("R2 event", d, 0);
    rd(A_MK, d); chk("R2 mask", d, 0);
    rd(A_CT, d); chk("R2 ctrl", d, 0);
    chk("R2 irq", {31'b0, irq_o}, 0);
    chk("R2 valid", {31'b0, next_valid_o}, 0);

    // R6 readback
    wr(A_MK, 32'h1234_5678); rd(A_MK, d); chk("R6 mask readback", d, 32'h1234_5678);
    wr(A_CT, 32'h8765_4321); rd(A_CT, d); chk("R6 ctrl readback", d, 32'h8765_4321);
    wr(A_CT, 32'h0); wr(A_MK, 32'hFFFF_FFFF);

    // R1 R3 R5 R7 R8: every line, both edges
    for (int n = 0; n < 32; n++) begin
      logic [31:0] b;
      b = 32'h1 << (31 - n);
      drive(32'h1 << n);
      rd(A_EV, d); chk("R1 R3 rise", d, b);
      chk_out("R8 single", b, 32'hFFFF_FFFF);
      wr(A_EV, b); rd(A_EV, d); chk("R5 clear", d, 0);
      chk("R7 irq low", {31'b0, irq_o}, 0);
      drive(32'h0);
      rd(A_EV, d); chk("R3 fall", d, b);
      wr(A_EV, b);
    end

    // R6 R7 R8 masking and multiple pending lines
    wr(A_MK, 32'h0);
    drive(32'h0010_0408);              // lines 3, 10, 20
    rd(A_EV, d); chk("R6 masked latch", d, 32'h1020_0800);
    chk_out("R7 masked", 32'h1020_0800, 32'h0);
    wr(A_MK, 32'h1000_0000);           // only line 3
    chk_out("R8 line3", 32'h1020_0800, 32'h1000_0000);
    wr(A_MK, 32'hFFFF_FFFF);
    chk_out("R8 highest", 32'h1020_0800, 32'hFFFF_FFFF);
    wr(A_EV, 32'h0);                   // zeros have no effect
    rd(A_EV, d); chk("R5 zero write", d, 32'h1020_0800);
    wr(A_EV, 32'h0000_0800);           // clear line 20
    chk_out("R8 after clear", 32'h1020_0000, 32'hFFFF_FFFF);
    wr(A_EV, 32'hFFFF_FFFF);
    drive(32'h0); wr(A_EV, 32'hFFFF_FFFF);

    // R4 falling only, each line
    wr(A_CT, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      drive(32'h1 << n);
      rd(A_EV, d); chk("R4 rise ignored", d, 0);
      drive(32'h0);
      rd(A_EV, d); chk("R4 fall", d, 32'h1 << (31 - n));
      wr(A_EV, d);
    end

    // R3 R4 mixed modes on all lines together
    wr(A_CT, 32'hAAAA_AAAA);
    drive(32'hFFFF_FFFF);
    rd(A_EV, d); chk("R4 mixed rise", d, ~32'hAAAA_AAAA);
    chk_out("R8 mixed", ~32'hAAAA_AAAA, 32'hFFFF_FFFF);
    wr(A_EV, 32'hFFFF_FFFF);
    drive(32'h0);
    rd(A_EV, d); chk("R3 mixed fall", d, 32'hFFFF_FFFF);
    chk_out("R8 all", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(A_EV, 32'hFFFF_FFFF);
    wr(A_CT, 32'h0);

    // R9 edge and clear in the same cycle (line 7, bit 24)
    drive(32'h80);
    rd(A_EV, d); chk("R9 setup", d, 32'h0100_0000);
    @(negedge clk); pin_i = 32'h0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = A_EV; reg_wdata = 32'h0100_0000; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(A_EV, d); chk("R9 edge wins", d, 32'h0100_0000);
    wr(A_EV, 32'h0100_0000);
    rd(A_EV, d); chk("R9 later clear", d, 0);

    // R10 unmapped offsets
    drive(32'h1);
    wr(A_MK, 32'h00FF_00FF); wr(A_CT, 32'h0F0F_0F0F);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h0E, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R10 read 00", d, 0);
    rd(8'h18, d); chk("R10 read 18", d, 0);
    rd(8'h0D, d); chk("R10 read 0D", d, 0);
    rd(A_MK, d); chk("R10 mask kept", d, 32'h00FF_00FF);
    rd(A_CT, d); chk("R10 ctrl kept", d, 32'h0F0F_0F0F);
    rd(A_EV, d); chk("R10 event kept", d, 32'h8000_0000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule